// File: doc/BRIEF.md
# Certainty Map Vote Accumulator

This block builds a two-dimensional histogram of object-centre guesses for one video frame. Each input event says that a corner at some (row, col) looked like a known part, and names that part by a codeword index. Every codeword owns a small table of signed (row, col) displacements. The block adds each displacement to the corner position to form a candidate centre. Candidates that fall outside the map are dropped. Each surviving candidate raises the matching map cell by one.

One event fans out into a fixed number of candidates, all computed in the same cycle. The candidates are then fed one per cycle through a queue into a read-modify-write pipeline on the map memory. A forwarding path keeps the count right when the same cell is hit on consecutive cycles. Cells saturate rather than wrap. A clear command lets the votes already in flight finish and then zeroes the whole map, one cell per cycle. The same sweep runs by itself after reset. A separate read port lets a consumer scan the finished map.

Top module: `certainty_map_acc`

## Requirements
- R1: After reset the block clears the map on its own. From the first cycle after reset until the sweep ends, `clr_busy` is 1 and `m_ready` is 0. Every cell then reads 0.
- R2: Each accepted event casts one candidate for every slot s in 0..NUM_VOTES-1, at (m_row + drow[cw][s], m_col + dcol[cw][s]). The offsets are OFS_W-bit two's-complement values.
- R3: A candidate with row < 0, row >= MAP_H, col < 0 or col >= MAP_W casts no vote and changes no cell.
- R4: A cell's linear address is row*MAP_W + col. When `rd_en` is high, `rd_valid` is 1 one cycle later and `rd_data` holds the addressed cell. An address of MAP_W*MAP_H or above reads as 0.
- R5: Every vote raises its cell by exactly one. Votes to the same cell on consecutive cycles are all counted, and so are repeated candidates within one event.
- R6: A cell stops at 2^CELL_W-1 and never wraps.
- R7: A one-cycle `clr_req` makes `clr_busy` 1 from the next cycle on. Votes already accepted are applied first. Then every cell is set to 0. `m_ready` stays 0 for as long as `clr_busy` is 1.
- R8: With `tbl_we` high, the pair (`tbl_drow`, `tbl_dcol`) is stored for codeword `tbl_cw` and slot `tbl_slot`. A write with `tbl_slot` >= NUM_VOTES changes nothing.
- R9: An event is taken on a clock edge where `m_valid` and `m_ready` are both 1. After taking an event that has at least one in-map candidate, `m_ready` drops to 0 until all of its candidates have been queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Offset table write strobe |
| tbl_cw | input | CW_W | Codeword index for the table write |
| tbl_slot | input | SLOT_W | Offset slot for the table write |
| tbl_drow | input | OFS_W | Signed row offset to store |
| tbl_dcol | input | OFS_W | Signed column offset to store |
| m_valid | input | 1 | Matched-corner event present |
| m_ready | output | 1 | Block can take an event |
| m_cw | input | CW_W | Codeword index of the match |
| m_row | input | ROW_W | Corner row |
| m_col | input | COL_W | Corner column |
| clr_req | input | 1 | Request to zero the map |
| clr_busy | output | 1 | Clear pending or in progress |
| rd_en | input | 1 | Map readout strobe |
| rd_addr | input | ADDR_W | Linear readout address |
| rd_valid | output | 1 | Readout data valid |
| rd_data | output | CELL_W | Cell value read |

## Verification
The offset tables are loaded from an arithmetic formula, so that the events it produces fall at the four corners and the mid-edges of the map. Some of their candidates spill off each side, which separates a correct bounds check from one that lets an off-by-one through or fails to treat sums as signed. One codeword is left with all-zero offsets: a single event then hits one cell nine times in a row, and repeating that event drives the cell past its limit. This exposes a missing forward or a counter that wraps. Two identical events sent back to back also test forwarding across events. Writes to slots past the last valid slot, and a clear issued while votes are still queued, show that ignored writes stay ignored and that a clear wipes both settled and in-flight votes.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

  // Candidate centre lies inside a map of h rows by w columns
  function automatic logic in_map(input int r, input int c, input int h, input int w);
    return (r >= 0) && (r < h) && (c >= 0) && (c < w);
  endfunction

  // Row-major flattening of a cell position
  function automatic int lin_addr(input int r, input int c, input int w);
    return r * w + c;
  endfunction

  // Increment that stops at the ceiling
  function automatic int sat_inc(input int v, input int ceiling);
    return (v >= ceiling) ? ceiling : v + 1;
  endfunction

endpackage

// File: rtl/cmap_vote_gen.sv
module cmap_vote_gen #(
  parameter int MAP_W     = 32,
  parameter int MAP_H     = 24,
  parameter int NUM_CW    = 8,
  parameter int NUM_VOTES = 9,
  parameter int OFS_W     = 6,
  parameter int ROW_W     = 5,
  parameter int COL_W     = 5,
  parameter int CW_W      = 3,
  parameter int SLOT_W    = 4,
  parameter int ADDR_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [CW_W-1:0]   tbl_cw,
  input  logic [SLOT_W-1:0] tbl_slot,
  input  logic [OFS_W-1:0]  tbl_drow,
  input  logic [OFS_W-1:0]  tbl_dcol,
  input  logic              accept_en,
  input  logic              m_valid,
  input  logic [CW_W-1:0]   m_cw,
  input  logic [ROW_W-1:0]  m_row,
  input  logic [COL_W-1:0]  m_col,
  output logic              m_ready,
  input  logic              fifo_full,
  output logic              push,
  output logic [ADDR_W-1:0] push_addr,
  output logic              idle
);

  localparam int CELLS = MAP_W * MAP_H;

  logic signed [OFS_W-1:0] drow_q [NUM_CW][NUM_VOTES];
  logic signed [OFS_W-1:0] dcol_q [NUM_CW][NUM_VOTES];

  logic [NUM_VOTES-1:0] hyp_ok;
  logic [ADDR_W-1:0]    hyp_addr [NUM_VOTES];
  logic [NUM_VOTES-1:0] pend_mask;
  logic [ADDR_W-1:0]    pend_addr [NUM_VOTES];

  logic              accept;
  logic              pick_found;
  logic [SLOT_W-1:0] pick_idx;

  // Offset table: one signed (row, col) pair per codeword and slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CW; i++) begin
        for (int j = 0; j < NUM_VOTES; j++) begin
          drow_q[i][j] <= '0;
          dcol_q[i][j] <= '0;
        end
      end
    end else if (tbl_we && (int'(tbl_slot) < NUM_VOTES) && (int'(tbl_cw) < NUM_CW)) begin
      drow_q[tbl_cw][tbl_slot] <= tbl_drow;
      dcol_q[tbl_cw][tbl_slot] <= tbl_dcol;
    end
  end

  // All candidates of one event formed side by side
  for (genvar v = 0; v < NUM_VOTES; v++) begin : g_hyp
    int hyp_r;
    int hyp_c;
    assign hyp_r       = int'(m_row) + int'(drow_q[m_cw][v]);
    assign hyp_c       = int'(m_col) + int'(dcol_q[m_cw][v]);
    assign hyp_ok[v]   = cmap_pkg::in_map(hyp_r, hyp_c, MAP_H, MAP_W);
    assign hyp_addr[v] = ADDR_W'(cmap_pkg::lin_addr(hyp_r, hyp_c, MAP_W));
  end

  assign idle    = (pend_mask == '0);
  assign m_ready = accept_en && idle;
  assign accept  = m_valid && m_ready;

  // Lowest pending slot goes first into the queue
  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int v = 0; v < NUM_VOTES; v++) begin
      if (pend_mask[v] && !pick_found) begin
        pick_found = 1'b1;
        pick_idx   = SLOT_W'(v);
      end
    end
  end

  assign push      = pick_found && !fifo_full;
  assign push_addr = pend_addr[pick_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_mask <= '0;
    end else if (accept) begin
      pend_mask <= hyp_ok;
    end else if (push) begin
      pend_mask[pick_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) pend_addr <= hyp_addr;
  end

  // R3: no candidate outside the map reaches the queue
  assert_vote_in_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(push_addr) < CELLS));

  // R2: each queued candidate retires exactly one pending slot
  assert_one_per_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> ($countones(pend_mask) == $countones($past(pend_mask)) - 1));

  // R9: no new event while candidates of the previous one are pending
  assert_hold_while_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_mask != '0) |-> !m_ready);

endmodule

// File: rtl/cmap_fifo.sv
module cmap_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic [PTR_W:0]   count;
  logic             do_push;
  logic             do_pop;

  assign full    = (int'(count) == DEPTH);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wptr] <= din;
  end

  // R5: a queued vote is never lost to overflow
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));

endmodule

// File: rtl/cmap_map_store.sv
module cmap_map_store #(
  parameter int CELLS  = 768,
  parameter int ADDR_W = 10,
  parameter int CELL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_req,
  input  logic              upstream_idle,
  input  logic              fifo_empty,
  input  logic [ADDR_W-1:0] fifo_dout,
  output logic              fifo_pop,
  output logic              clr_busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [CELL_W-1:0] rd_data
);

  localparam int CELL_MAX = (1 << CELL_W) - 1;

  logic [CELL_W-1:0] cells [CELLS];

  logic              clr_pending;
  logic              clr_active;
  logic [ADDR_W-1:0] clr_ptr;
  logic              clr_start;
  logic              clr_last;
  logic              pipe_idle;

  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr;
  logic [CELL_W-1:0] rmw_q;
  logic              wb_valid;
  logic [ADDR_W-1:0] wb_addr;
  logic [CELL_W-1:0] wb_val;

  logic              fwd_hit;
  logic [CELL_W-1:0] cell_base;
  logic [CELL_W-1:0] cell_new;

  // Stage 0: take a vote from the queue and read its cell
  assign fifo_pop  = !fifo_empty && !clr_active;

  // Stage 1: last cycle's write is not yet visible in rmw_q, so forward it
  assign fwd_hit   = s1_valid && wb_valid && (wb_addr == s1_addr);
  assign cell_base = fwd_hit ? wb_val : rmw_q;
  assign cell_new  = CELL_W'(cmap_pkg::sat_inc(int'(cell_base), CELL_MAX));

  // The sweep waits until every accepted vote has landed
  assign pipe_idle = upstream_idle && fifo_empty && !s1_valid;
  assign clr_start = clr_pending && pipe_idle;
  assign clr_last  = clr_active && (int'(clr_ptr) == CELLS - 1);
  assign clr_busy  = clr_pending || clr_active;

  always_ff @(posedge clk) begin
    if (clr_active) begin
      cells[clr_ptr] <= '0;
    end else if (s1_valid) begin
      cells[s1_addr] <= cell_new;
    end
    if (fifo_pop) rmw_q <= cells[fifo_dout];
    if (rd_en) rd_data <= (int'(rd_addr) < CELLS) ? cells[rd_addr] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_pending <= 1'b1;
      clr_active  <= 1'b0;
      clr_ptr     <= '0;
      s1_valid    <= 1'b0;
      s1_addr     <= '0;
      wb_valid    <= 1'b0;
      wb_addr     <= '0;
      wb_val      <= '0;
      rd_valid    <= 1'b0;
    end else begin
      if (clr_start) begin
        clr_pending <= 1'b0;
      end else if (clr_req && !clr_active) begin
        clr_pending <= 1'b1;
      end

      if (clr_start) begin
        clr_active <= 1'b1;
        clr_ptr    <= '0;
      end else if (clr_last) begin
        clr_active <= 1'b0;
      end else if (clr_active) begin
        clr_ptr <= clr_ptr + 1'b1;
      end

      s1_valid <= fifo_pop;
      s1_addr  <= fifo_dout;
      wb_valid <= s1_valid;
      wb_addr  <= s1_addr;
      wb_val   <= cell_new;
      rd_valid <= rd_en;
    end
  end

  // R7: the sweep never overlaps a vote update
  assert_clear_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |-> (!s1_valid && !fifo_pop));

  // R7: a sweep ends only after the last cell
  assert_sweep_complete_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_active) |-> (int'($past(clr_ptr)) == CELLS - 1));

  // R5: back-to-back hits on one cell step it by one each time
  assert_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && $past(s1_valid) && (s1_addr == $past(s1_addr)))
      |-> ((cell_new == CELL_W'($past(cell_new) + 1'b1)) || (int'(cell_new) == CELL_MAX)));

  // R6: an incremented cell never wraps to zero
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (cell_new != '0));

  // R4: readout answers one cycle after the request
  assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

endmodule

// File: rtl/certainty_map_acc.sv
module certainty_map_acc #(
  parameter int MAP_W      = 32,
  parameter int MAP_H      = 24,
  parameter int CELL_W     = 8,
  parameter int NUM_CW     = 8,
  parameter int NUM_VOTES  = 9,
  parameter int OFS_W      = 6,
  parameter int FIFO_DEPTH = 16,
  localparam int ROW_W  = $clog2(MAP_H),
  localparam int COL_W  = $clog2(MAP_W),
  localparam int CW_W   = $clog2(NUM_CW),
  localparam int SLOT_W = $clog2(NUM_VOTES),
  localparam int CELLS  = MAP_W * MAP_H,
  localparam int ADDR_W = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [CW_W-1:0]   tbl_cw,
  input  logic [SLOT_W-1:0] tbl_slot,
  input  logic [OFS_W-1:0]  tbl_drow,
  input  logic [OFS_W-1:0]  tbl_dcol,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic [CW_W-1:0]   m_cw,
  input  logic [ROW_W-1:0]  m_row,
  input  logic [COL_W-1:0]  m_col,
  input  logic              clr_req,
  output logic              clr_busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [CELL_W-1:0] rd_data
);

  logic              vote_push;
  logic [ADDR_W-1:0] vote_addr;
  logic              gen_idle;
  logic              q_full;
  logic              q_empty;
  logic              q_pop;
  logic [ADDR_W-1:0] q_dout;

  cmap_vote_gen #(
    .MAP_W(MAP_W), .MAP_H(MAP_H), .NUM_CW(NUM_CW), .NUM_VOTES(NUM_VOTES),
    .OFS_W(OFS_W), .ROW_W(ROW_W), .COL_W(COL_W), .CW_W(CW_W),
    .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_cw(tbl_cw), .tbl_slot(tbl_slot),
    .tbl_drow(tbl_drow), .tbl_dcol(tbl_dcol),
    .accept_en(!clr_busy),
    .m_valid(m_valid), .m_cw(m_cw), .m_row(m_row), .m_col(m_col),
    .m_ready(m_ready),
    .fifo_full(q_full), .push(vote_push), .push_addr(vote_addr),
    .idle(gen_idle)
  );

  cmap_fifo #(.WIDTH(ADDR_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(vote_push), .din(vote_addr),
    .pop(q_pop), .dout(q_dout),
    .full(q_full), .empty(q_empty)
  );

  cmap_map_store #(.CELLS(CELLS), .ADDR_W(ADDR_W), .CELL_W(CELL_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .clr_req(clr_req), .upstream_idle(gen_idle),
    .fifo_empty(q_empty), .fifo_dout(q_dout), .fifo_pop(q_pop),
    .clr_busy(clr_busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R7: events are refused for the whole clear
  assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !m_ready);

  // R1: the first cycle after reset is already clearing
  assert_reset_clears_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> clr_busy);

endmodule

// File: tb/test_certainty_map_acc.sv
module test_certainty_map_acc;

  localparam int MAP_W  = 32;
  localparam int MAP_H  = 24;
  localparam int CELLS  = MAP_W * MAP_H;
  localparam int NCW    = 8;
  localparam int NV     = 9;
  localparam int CMAX   = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_we = 1'b0;
  logic [2:0] tbl_cw = '0;
  logic [3:0] tbl_slot = '0;
  logic [5:0] tbl_drow = '0;
  logic [5:0] tbl_dcol = '0;
  logic       m_valid = 1'b0;
  logic       m_ready;
  logic [2:0] m_cw = '0;
  logic [4:0] m_row = '0;
  logic [4:0] m_col = '0;
  logic       clr_req = 1'b0;
  logic       clr_busy;
  logic       rd_en = 1'b0;
  logic [9:0] rd_addr = '0;
  logic       rd_valid;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int model [CELLS];

  certainty_map_acc i_certainty_map_acc (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_cw(tbl_cw), .tbl_slot(tbl_slot),
    .tbl_drow(tbl_drow), .tbl_dcol(tbl_dcol),
    .m_valid(m_valid), .m_ready(m_ready), .m_cw(m_cw), .m_row(m_row), .m_col(m_col),
    .clr_req(clr_req), .clr_busy(clr_busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Offsets the bench loads, restated where votes are predicted
  function automatic int ofs_r(input int cw, input int v);
    return (cw == 7) ? 0 : ((cw * 3 + v * 5) % 13) - 6;
  endfunction
  function automatic int ofs_c(input int cw, input int v);
    return (cw == 7) ? 0 : ((cw * 7 + v * 3) % 11) - 5;
  endfunction

  task automatic tbl_write(input int cw, input int slot, input int dr, input int dc);
    tbl_we   = 1'b1;
    tbl_cw   = 3'(cw);
    tbl_slot = 4'(slot);
    tbl_drow = 6'(dr);
    tbl_dcol = 6'(dc);
    tick();
    tbl_we   = 1'b0;
  endtask

  task automatic send(input int cw, input int r, input int c);
    int nvalid = 0;
    m_valid = 1'b1;
    m_cw    = 3'(cw);
    m_row   = 5'(r);
    m_col   = 5'(c);
    while (!m_ready) tick();
    tick();
    m_valid = 1'b0;
    for (int v = 0; v < NV; v++) begin
      int hr = r + ofs_r(cw, v);
      int hc = c + ofs_c(cw, v);
      if (hr >= 0 && hr < MAP_H && hc >= 0 && hc < MAP_W) begin
        nvalid++;
        if (model[hr * MAP_W + hc] < CMAX) model[hr * MAP_W + hc]++;
      end
    end
    if (nvalid > 0) chk("R9", int'(m_ready), 0, "ready after accept");
  endtask

  task automatic read_cell(input int a, output int val, output int vld);
    rd_en   = 1'b1;
    rd_addr = 10'(a);
    tick();
    rd_en   = 1'b0;
    val     = int'(rd_data);
    vld     = int'(rd_valid);
  endtask

  task automatic sweep(input string req);
    int val;
    int vld;
    for (int a = 0; a < CELLS; a++) begin
      read_cell(a, val, vld);
      chk(req, val, model[a], $sformatf("cell %0d", a));
    end
  endtask

  task automatic wait_clear();
    int guard = 0;
    while (clr_busy && guard < 5000) begin
      tick();
      guard++;
    end
    chk("R7", int'(clr_busy), 0, "clear finished");
    for (int a = 0; a < CELLS; a++) model[a] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int val;
    int vld;
    for (int a = 0; a < CELLS; a++) model[a] = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: auto-clear after reset
    chk("R1", int'(clr_busy), 1, "busy after reset");
    chk("R1", int'(m_ready), 0, "ready after reset");
    wait_clear();
    sweep("R1");

    // R8: load tables; writes to slots past the end must be ignored
    for (int cw = 0; cw < NCW; cw++)
      for (int v = 0; v < NV; v++)
        tbl_write(cw, v, ofs_r(cw, v), ofs_c(cw, v));
    for (int s = NV; s < 16; s++) tbl_write(1, s, 1, 1);

    // R2 R3: events at corners and edges, with candidates spilling off each side
    send(0, 0, 0);
    send(1, 23, 31);
    send(2, 0, 31);
    send(3, 23, 0);
    send(4, 12, 16);
    send(5, 3, 29);
    send(6, 20, 2);
    send(1, 11, 0);
    // R5: identical events back to back, and nine hits on one cell
    send(2, 10, 10);
    send(2, 10, 10);
    send(7, 6, 6);
    repeat (40) tick();
    sweep("R2");

    // R4: readout timing and out-of-range address
    read_cell(1000, val, vld);
    chk("R4", vld, 1, "rd_valid one cycle later");
    chk("R4", val, 0, "address past map");
    tick();
    chk("R4", int'(rd_valid), 0, "rd_valid drops");

    // R6: saturation, 30 events x 9 votes on one cell
    for (int k = 0; k < 30; k++) send(7, 15, 20);
    repeat (40) tick();
    read_cell(15 * MAP_W + 20, val, vld);
    chk("R6", val, CMAX, "saturated cell");
    read_cell(15 * MAP_W + 21, val, vld);
    chk("R6", val, model[15 * MAP_W + 21], "neighbour untouched");
    sweep("R5");

    // R7: clear issued while votes are still queued
    send(4, 5, 5);
    send(5, 18, 25);
    clr_req = 1'b1;
    tick();
    clr_req = 1'b0;
    chk("R7", int'(clr_busy), 1, "busy after request");
    chk("R7", int'(m_ready), 0, "ready during clear");
    wait_clear();
    sweep("R7");

    // R3: after the clear, one event with most candidates off the map
    send(0, 0, 0);
    repeat (40) tick();
    sweep("R3");

    finish_run();
  end

endmodule